// File: doc/BRIEF.md
# TDM Highway Time Slot Access

This block attaches one byte-wide channel to a single time slot of a framed serial TDM highway. The highway bit clock, frame sync and receive line are inputs that the block samples with its own system clock. From them it rebuilds the bit position within the current frame. In the chosen slot it shifts one byte out on the transmit line and drives an output enable, and it shifts one byte in from the receive line. The result is one received byte and one transmitted byte per frame.

The two directions are set up independently. Each has its own slot number, a slot offset and a bit offset that move slot zero away from the frame sync, and a choice of which highway clock edge launches or samples its bits. A global enable gates all highway activity. A polarity control picks the active level of frame sync.

Top module: `tdm_slot_access`

## Requirements
- R1: After reset `hw_txd_oe`, `hw_txd`, `rx_valid` and `tx_ack` are 0.
- R2: While `hw_en` is 0 the output enable stays low and no `rx_valid` or `tx_ack` pulse occurs. After `hw_en` returns to 1, nothing happens until the next frame start.
- R3: A frame start is a rising edge of `hw_clk` at which `hw_fs` is at its active level (high when `fs_pol` = 1, low when `fs_pol` = 0) and at the previous rising edge it was not. Bit time 0 begins at that edge, and bit time n begins at the n-th rising edge after it. A sync held active over several rising edges starts only one frame.
- R4: For either direction, bit b (0..7) of the selected slot s occupies bit time `ts_off*8 + bit_off + 8*s + b`. The slot, slot-offset and bit-offset fields are 6, 6 and 3 bits wide, and positions up to bit time 1022 are reachable.
- R5: With `tx_edge_inv` = 0 a transmit bit is launched at the rising edge that begins its bit time. With `tx_edge_inv` = 1 it is launched at the falling edge inside that bit time.
- R6: With `rx_edge_inv` = 0 a receive bit is sampled at the falling edge inside its bit time. With `rx_edge_inv` = 1 it is sampled at the rising edge that ends it.
- R7: `hw_txd_oe` is high exactly during the 8 transmit bit times of the selected slot. `hw_txd` is 0 whenever the enable is low.
- R8: Both directions carry the most significant bit first. `tx_byte` is captured when bit 7 is launched, and `tx_ack` pulses for one system clock at that moment, once per frame.
- R9: After the eighth bit of the selected receive slot is sampled, `rx_valid` is high for exactly one system clock with that byte on `rx_byte`. `rx_byte` then holds until the next completed byte.
- R10: Transmit and receive settings act independently, so the two directions may use different slots, offsets and edges in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Global highway enable |
| fs_pol | input | 1 | Frame sync active level (1 = high) |
| hw_clk | input | 1 | Highway bit clock |
| hw_fs | input | 1 | Highway frame sync |
| hw_rxd | input | 1 | Highway serial receive data |
| tx_slot | input | 6 | Transmit slot number |
| tx_ts_off | input | 6 | Transmit slot offset from frame sync |
| tx_bit_off | input | 3 | Transmit bit offset from frame sync |
| tx_edge_inv | input | 1 | Transmit launch edge select |
| rx_slot | input | 6 | Receive slot number |
| rx_ts_off | input | 6 | Receive slot offset from frame sync |
| rx_bit_off | input | 3 | Receive bit offset from frame sync |
| rx_edge_inv | input | 1 | Receive sample edge select |
| tx_byte | input | 8 | Byte to send in the next transmit slot |
| tx_ack | output | 1 | One-clock pulse when tx_byte is captured |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock pulse when rx_byte is new |
| hw_txd | output | 1 | Highway serial transmit data |
| hw_txd_oe | output | 1 | Transmit output enable |

## Verification
A highway clock edge is registered on the next system clock. `hw_txd` and `hw_txd_oe` therefore change on the second system clock after the launching edge, and `rx_valid` rises on the second system clock after the edge that samples the eighth bit. The bench changes highway signals only on the falling system clock. It reads transmit bits half a bit time after launch, just before the opposite highway edge, where the line is settled for either edge choice. A monitor compares every `rx_valid` pulse at the falling system clock against the byte expected for that frame. The pulse counts per run are then compared with the number of frames, which catches both missing and stretched pulses.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
    localparam int SLOT_W = 6;
    localparam int BOFF_W = 3;
    localparam int BYTE_W = 2 ** BOFF_W;
    localparam int IDX_W  = SLOT_W + BOFF_W + 1;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] ts_off;
        logic [BOFF_W-1:0] bit_off;
        logic              edge_inv;
    } dir_cfg_t;

    // first bit time of the selected slot, counted from the frame start
    function automatic logic [IDX_W-1:0] slot_base(dir_cfg_t c);
        return IDX_W'({c.ts_off, c.bit_off}) + IDX_W'({c.slot, {BOFF_W{1'b0}}});
    endfunction

    function automatic logic in_slot(logic [IDX_W-1:0] idx, dir_cfg_t c);
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] rel;
        base = slot_base(c);
        rel  = idx - base;
        return (idx >= base) && (rel < IDX_W'(BYTE_W));
    endfunction

    function automatic logic [BOFF_W-1:0] slot_bit(logic [IDX_W-1:0] idx, dir_cfg_t c);
        logic [IDX_W-1:0] rel;
        rel = idx - slot_base(c);
        return rel[BOFF_W-1:0];
    endfunction
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_clk,
    input  logic hw_fs,
    input  logic hw_rxd,
    output logic rise_stb,
    output logic fall_stb,
    output logic fs_s,
    output logic rxd_s
);
    typedef struct packed {
        logic clk1;
        logic clk2;
        logic fs1;
        logic rx1;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.clk1 = hw_clk;
        d.clk2 = q.clk1;
        d.fs1  = hw_fs;
        d.rx1  = hw_rxd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_stb = q.clk1 & ~q.clk2;
    assign fall_stb = ~q.clk1 & q.clk2;
    assign fs_s     = q.fs1;
    assign rxd_s    = q.rx1;
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             fs_pol,
    input  logic             rise_stb,
    input  logic             fs_s,
    output logic [IDX_W-1:0] idx_q,
    output logic [IDX_W-1:0] idx_nxt,
    output logic             lock_q,
    output logic             lock_nxt
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             lock;
        logic             fs_prev;
    } timer_t;

    timer_t q, d;
    logic   fs_act;

    always_comb begin
        d      = q;
        fs_act = (fs_s == fs_pol);
        if (!hw_en) d.lock = 1'b0;
        if (rise_stb) begin
            if (hw_en && fs_act && !q.fs_prev) begin
                d.idx  = '0;
                d.lock = 1'b1;
            end else if (!(&q.idx)) begin
                d.idx = q.idx + 1'b1;
            end
            d.fs_prev = fs_act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idx_q    = q.idx;
    assign idx_nxt  = d.idx;
    assign lock_q   = q.lock;
    assign lock_nxt = d.lock;

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_stb |=> $stable(idx_q));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> (idx_q == '0) || (idx_q == $past(idx_q) + 1'b1) || (&idx_q));
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  dir_cfg_t          cfg,
    input  logic [IDX_W-1:0]  idx_nxt,
    input  logic              lock_nxt,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              txd,
    output logic              txd_oe,
    output logic              tx_ack
);
    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic              txd;
        logic              oe;
        logic              ack;
    } tx_t;

    tx_t               q, d;
    logic              stb;
    logic [BOFF_W-1:0] pos;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        stb   = cfg.edge_inv ? fall_stb : rise_stb;
        pos   = slot_bit(idx_nxt, cfg);
        if (!hw_en) begin
            d.oe  = 1'b0;
            d.txd = 1'b0;
        end else if (stb) begin
            if (lock_nxt && in_slot(idx_nxt, cfg)) begin
                d.oe = 1'b1;
                if (pos == '0) begin
                    d.hold = tx_byte;
                    d.txd  = tx_byte[BYTE_W-1];
                    d.ack  = 1'b1;
                end else begin
                    d.txd = q.hold[BOFF_W'(BYTE_W-1) - pos];
                end
            end else begin
                d.oe  = 1'b0;
                d.txd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign txd    = q.txd;
    assign txd_oe = q.oe;
    assign tx_ack = q.ack;

    // R2
    tx_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |=> !txd_oe && !tx_ack);

    // R5
    tx_launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && !stb) |=> $stable(txd) && $stable(txd_oe));
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              rxd_s,
    input  dir_cfg_t          cfg,
    input  logic [IDX_W-1:0]  idx_q,
    input  logic              lock_q,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] data;
        logic              valid;
    } rx_t;

    rx_t  q, d;
    logic stb;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        stb     = cfg.edge_inv ? rise_stb : fall_stb;
        if (hw_en && stb && lock_q && in_slot(idx_q, cfg)) begin
            d.shreg = {q.shreg[BYTE_W-2:0], rxd_s};
            if (slot_bit(idx_q, cfg) == BOFF_W'(BYTE_W-1)) begin
                d.data  = {q.shreg[BYTE_W-2:0], rxd_s};
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte  = q.data;
    assign rx_valid = q.valid;

    // R9
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    rx_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));

    // R6
    rx_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(stb) && $past(hw_en));
endmodule

// File: rtl/tdm_slot_access.sv
module tdm_slot_access
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              fs_pol,
    input  logic              hw_clk,
    input  logic              hw_fs,
    input  logic              hw_rxd,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [SLOT_W-1:0] tx_ts_off,
    input  logic [BOFF_W-1:0] tx_bit_off,
    input  logic              tx_edge_inv,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [SLOT_W-1:0] rx_ts_off,
    input  logic [BOFF_W-1:0] rx_bit_off,
    input  logic              rx_edge_inv,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_ack,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              hw_txd,
    output logic              hw_txd_oe
);
    logic             rise_stb, fall_stb, fs_s, rxd_s;
    logic [IDX_W-1:0] idx_q, idx_nxt;
    logic             lock_q, lock_nxt;
    dir_cfg_t         tx_cfg, rx_cfg;

    assign tx_cfg = '{slot: tx_slot, ts_off: tx_ts_off, bit_off: tx_bit_off, edge_inv: tx_edge_inv};
    assign rx_cfg = '{slot: rx_slot, ts_off: rx_ts_off, bit_off: rx_bit_off, edge_inv: rx_edge_inv};

    tdm_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_clk   (hw_clk),
        .hw_fs    (hw_fs),
        .hw_rxd   (hw_rxd),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .fs_s     (fs_s),
        .rxd_s    (rxd_s)
    );

    tdm_frame_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_en    (hw_en),
        .fs_pol   (fs_pol),
        .rise_stb (rise_stb),
        .fs_s     (fs_s),
        .idx_q    (idx_q),
        .idx_nxt  (idx_nxt),
        .lock_q   (lock_q),
        .lock_nxt (lock_nxt)
    );

    tdm_slot_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_en    (hw_en),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .cfg      (tx_cfg),
        .idx_nxt  (idx_nxt),
        .lock_nxt (lock_nxt),
        .tx_byte  (tx_byte),
        .txd      (hw_txd),
        .txd_oe   (hw_txd_oe),
        .tx_ack   (tx_ack)
    );

    tdm_slot_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_en    (hw_en),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .rxd_s    (rxd_s),
        .cfg      (rx_cfg),
        .idx_q    (idx_q),
        .lock_q   (lock_q),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    // R8
    oe_starts_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_txd_oe && !$past(hw_txd_oe)) |-> tx_ack);

    // R7
    txd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_txd_oe |-> !hw_txd);
endmodule

// File: tb/tdm_slot_access_bench.sv
`timescale 1ns/1ps
module tdm_slot_access_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0, fs_pol = 1'b1, hw_clk = 1'b0, hw_fs = 1'b0, hw_rxd = 1'b0;
    logic [5:0] tx_slot = '0, tx_ts_off = '0, rx_slot = '0, rx_ts_off = '0;
    logic [2:0] tx_bit_off = '0, rx_bit_off = '0;
    logic       tx_edge_inv = 1'b0, rx_edge_inv = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_ack, rx_valid, hw_txd, hw_txd_oe;
    logic [7:0] rx_byte;

    int chk = 0, err = 0;
    int mon_chk = 0, mon_err = 0;
    int rx_total = 0, ack_total = 0, rx_base = 0;
    int cyc = 0;
    int last_len = 2000;
    bit done = 0;
    logic [7:0] exp_rx [0:7];

    always #2.5 clk = ~clk;

    tdm_slot_access u_tdm_slot_access (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .fs_pol(fs_pol),
        .hw_clk(hw_clk), .hw_fs(hw_fs), .hw_rxd(hw_rxd),
        .tx_slot(tx_slot), .tx_ts_off(tx_ts_off), .tx_bit_off(tx_bit_off), .tx_edge_inv(tx_edge_inv),
        .rx_slot(rx_slot), .rx_ts_off(rx_ts_off), .rx_bit_off(rx_bit_off), .rx_edge_inv(rx_edge_inv),
        .tx_byte(tx_byte), .tx_ack(tx_ack), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .hw_txd(hw_txd), .hw_txd_oe(hw_txd_oe)
    );

    // receive monitor: R9 byte content, R6 sampling edge, R8 bit order
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_total - rx_base < 8) begin
                mon_chk++;
                if (rx_byte !== exp_rx[rx_total - rx_base]) begin
                    mon_err++;
                    $display("FAIL R6 R8 R9 rx_byte act=%0h exp=%0h", rx_byte, exp_rx[rx_total - rx_base]);
                end
            end
            rx_total++;
        end
        if (rst_n && tx_ack) ack_total++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 195000 && !done) begin
            $display("FAIL watchdog act=%0d exp=finished", cyc);
            $display("CHECKS %0d ERRORS %0d", chk + mon_chk + 1, err + mon_err + 1);
            $finish;
        end
    end

    task automatic check(string tag, int act, int expv);
        chk++;
        if (act !== expv) begin
            err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic int base_of(int slot, int tso, int bo);
        return tso * 8 + bo + slot * 8;
    endfunction

    // {oe, data} expected in transmit bit time j
    function automatic logic [1:0] exp_tx(int j, int base, logic [7:0] b, bit en);
        int rel = j - base;
        if (en && j >= base && rel < 8) return {1'b1, b[7 - rel]};
        return 2'b00;
    endfunction

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic run_call(bit en, bit pol, int ts, int tt, int tb, bit ti,
                            int rs, int rt, int rb, bit ri, int nslots, int frames, int fs_len);
        int L = nslots * 8;
        int tbase = base_of(ts, tt, tb);
        int rbase = base_of(rs, rt, rb);
        logic [7:0] txb [0:7];
        int rx0 = rx_total;
        int ack0 = ack_total;
        logic [1:0] e;
        hw_en = en; fs_pol = pol;
        tx_slot = 6'(ts); tx_ts_off = 6'(tt); tx_bit_off = 3'(tb); tx_edge_inv = ti;
        rx_slot = 6'(rs); rx_ts_off = 6'(rt); rx_bit_off = 3'(rb); rx_edge_inv = ri;
        for (int f = 0; f < frames; f++) begin
            txb[f] = 8'($urandom);
            exp_rx[f] = 8'($urandom);
        end
        rx_base = rx_total;
        hw_fs = pol;
        half();
        for (int f = 0; f < frames; f++) begin
            for (int k = 0; k < L; k++) begin
                // rising edge: launch edge for tx_edge_inv = 0 (R5)
                if (ti && (k > 0 || f > 0)) begin
                    e = exp_tx(k > 0 ? k - 1 : L - 1, tbase, k > 0 ? txb[f] : txb[f - 1], en);
                    check("R5 R7 oe", int'(hw_txd_oe), int'(e[1]));
                    check("R4 R8 txd", int'(hw_txd), int'(e[0]));
                end
                hw_clk = 1'b1;
                if (k == 0) tx_byte = txb[f];
                if (!ri) hw_rxd = (k >= rbase && k - rbase < 8) ? exp_rx[f][7 - (k - rbase)] : 1'($urandom);
                half();
                if (!ti) begin
                    e = exp_tx(k, tbase, txb[f], en);
                    check("R5 R7 oe", int'(hw_txd_oe), int'(e[1]));
                    check("R4 R8 txd", int'(hw_txd), int'(e[0]));
                end
                hw_clk = 1'b0;
                if (ri) hw_rxd = (k >= rbase && k - rbase < 8) ? exp_rx[f][7 - (k - rbase)] : 1'($urandom);
                hw_fs = ((k < fs_len - 1) || (k == L - 1 && f < frames - 1)) ? pol : ~pol;
                half();
            end
        end
        if (ti) begin
            e = exp_tx(L - 1, tbase, txb[frames - 1], en);
            check("R7 last oe", int'(hw_txd_oe), int'(e[1]));
        end
        hw_clk = 1'b1;
        half();
        hw_clk = 1'b0;
        hw_fs = ~pol;
        half();
        check("R2 R9 rx count", rx_total - rx0, en ? frames : 0);
        check("R2 R8 ack count", ack_total - ack0, en ? frames : 0);
        last_len = L;
    endtask

    function automatic bit cfg_ok(int slot, int tso, int bo, int L);
        int b = base_of(slot, tso, bo);
        if (b + 8 > L - 1) return 0;
        if (last_len >= b && last_len < b + 8) return 0;
        return 1;
    endfunction

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 oe", int'(hw_txd_oe), 0);
        check("R1 txd", int'(hw_txd), 0);
        check("R1 rx_valid", int'(rx_valid), 0);
        check("R1 tx_ack", int'(tx_ack), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // directed: slot 0, no offsets, both edges default (R4 R5 R6)
        run_call(1, 1, 0, 0, 0, 0,  0, 0, 0, 0,  4, 2, 1);
        // R3 low-active sync held across three rising edges, inverted edges
        run_call(1, 0, 2, 0, 0, 1,  1, 0, 3, 1,  6, 3, 3);
        // R2 highway disabled
        run_call(0, 1, 1, 0, 0, 0,  1, 0, 0, 0,  4, 2, 1);
        // R4 largest offsets on slot 0, and slot 63 in the other direction (R10)
        run_call(1, 1, 0, 63, 7, 0,  63, 0, 3, 1,  66, 2, 1);
        // R4 highest reachable position, bit time 1022
        run_call(1, 1, 63, 63, 7, 1,  63, 63, 7, 0,  128, 2, 2);

        // random configurations, independent per direction (R10)
        for (int r = 0; r < 14; r++) begin
            int n, ts, tt, tb, rs, rt, rb;
            n = 4 + int'($urandom % 13);
            do begin
                ts = int'($urandom % n); tt = int'($urandom % n); tb = int'($urandom % 8);
            end while (!cfg_ok(ts, tt, tb, n * 8));
            do begin
                rs = int'($urandom % n); rt = int'($urandom % n); rb = int'($urandom % 8);
            end while (!cfg_ok(rs, rt, rb, n * 8));
            run_call(($urandom % 6) != 0, 1'($urandom), ts, tt, tb, 1'($urandom),
                     rs, rt, rb, 1'($urandom), n, 2 + int'($urandom % 3), 1 + int'($urandom % 3));
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", chk + mon_chk, err + mon_err);
        $finish;
    end
endmodule